// File: doc/BRIEF.md
# Parallel-Prefix Carry-Lookahead Adder

This block adds two unsigned binary operands and a carry-in, and returns the sum together with the carry-out. It does not let the carry ripple. Each bit pair is first classed as one of three carry states: the bit produces a carry, blocks a carry, or passes along the carry it receives. The carry-in is placed below bit 0 as an extra position that either produces a carry or blocks one. An associative merge operator then combines these states in a doubling network. At level k, every position merges its current state with the state 2^k positions below it. After log2(WIDTH) levels, each position holds the resolved carry into the bit above it.

Each sum bit is the exclusive-or of the two operand bits and the resolved carry into that bit. The carry-out is the top bit's own state merged with the carry that reaches the top bit. By default one output register follows the network, so results appear one clock after the operands. With `REG_OUT` set to 0, the outputs are purely combinational.

Top module: `pfx_cla_adder`

## Requirements
- R1: Bit i is classed by its operand bits. If both are 1 (produce), the carry out of bit i is 1. If both are 0 (block), the carry out of bit i is 0. If they differ (pass), the carry out of bit i equals the carry into bit i.
- R2: The merge of a higher state with a lower state gives the higher state, unless the higher state is pass; in that case it gives the lower state. So a run of pass bits takes the state of the nearest non-pass position below it.
- R3: The carry-in acts as a position below bit 0. It produces a carry when `cin_i` is 1 and blocks one when `cin_i` is 0, so the carry into bit 0 equals `cin_i`.
- R4: All carries resolve within one evaluation through log2(WIDTH) doubling levels. A carry entering at the bottom reaches the carry-out across a full-width chain of pass bits, for example all-ones plus zero plus carry-in 1 gives sum 0 and carry-out 1.
- R5: `{cout_o, sum_o}` equals the unsigned sum `a_i + b_i + cin_i`, with each sum bit being a XOR b XOR the carry into that bit.
- R6: `cout_o` is 1 exactly when the resolved state of the top bit is produce. For example, all-ones plus zero gives carry-out 0 with carry-in 0, and 1 with carry-in 1.
- R7: With `REG_OUT` = 1 (the default), the outputs show the result of the operands sampled at the previous rising clock edge. A synchronous active-low `rst_n` clears `sum_o` and `cout_o` to 0 whatever the operands are.
- R8: With `REG_OUT` = 0, the outputs follow the operands in the same cycle with no clock involved. This holds at every width, including 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry-out |

## Verification
The assertions assume that the operands and carry-in are settled and 0/1-valued at each rising clock edge, because the per-bit carry checks and the result check sample them there. The bench drives every input on the falling edge and holds it across the following rising edge, so that assumption holds. The registered result check also assumes the operands at the previous edge were taken outside reset. The checker therefore waits one edge after reset is released, and the bench holds reset for whole cycles.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // Carry state of one position in the prefix network.
  typedef enum logic [1:0] {
    CS_KILL = 2'b00,
    CS_GEN  = 2'b01,
    CS_PROP = 2'b10
  } cstate_e;

  // Class of a single bit pair.
  function automatic cstate_e classify(input logic x, input logic y);
    if (x & y)      return CS_GEN;
    else if (x ^ y) return CS_PROP;
    else            return CS_KILL;
  endfunction

  // Associative merge: the higher state wins unless it only passes.
  function automatic cstate_e merge(input cstate_e hi, input cstate_e lo);
    return (hi == CS_PROP) ? lo : hi;
  endfunction

  // State of the virtual position standing in for the carry-in.
  function automatic cstate_e seed(input logic cin);
    return cin ? CS_GEN : CS_KILL;
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  input  logic                cin_i,
  output cstate_e [WIDTH-1:0] pos_o,   // position 0 = carry-in, p = bit p-1
  output cstate_e             top_o    // state of the most significant bit
);

  assign pos_o[0] = seed(cin_i);

  for (genvar p = 1; p < WIDTH; p++) begin : g_pos
    assign pos_o[p] = classify(a_i[p-1], b_i[p-1]);
  end

  assign top_o = classify(a_i[WIDTH-1], b_i[WIDTH-1]);

endmodule

// File: rtl/pfx_level.sv
module pfx_level
  import pfx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  cstate_e [WIDTH-1:0] in_i,
  output cstate_e [WIDTH-1:0] out_o
);

  for (genvar p = 0; p < WIDTH; p++) begin : g_node
    if (p >= DIST) begin : g_merge
      assign out_o[p] = merge(in_i[p], in_i[p-DIST]);
    end else begin : g_pass
      assign out_o[p] = in_i[p];
    end
  end

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum
  import pfx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  input  cstate_e [WIDTH-1:0] pre_i,    // resolved prefix per position
  input  cstate_e             top_i,
  output logic [WIDTH:0]      carry_o,  // carry into bit i; [WIDTH] = carry-out
  output logic [WIDTH-1:0]    sum_o,
  output logic                cout_o
);

  for (genvar p = 0; p < WIDTH; p++) begin : g_carry
    assign carry_o[p] = (pre_i[p] == CS_GEN);
  end

  assign carry_o[WIDTH] = (merge(top_i, pre_i[WIDTH-1]) == CS_GEN);
  assign cout_o         = carry_o[WIDTH];
  assign sum_o          = a_i ^ b_i ^ carry_o[WIDTH-1:0];

endmodule

// File: rtl/pfx_cla_adder.sv
module pfx_cla_adder
  import pfx_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int LEVELS = $clog2(WIDTH);

  cstate_e [WIDTH-1:0] stage [LEVELS+1];
  cstate_e             top_w;
  logic [WIDTH:0]      carry_w;   // named carries, observed by the checker
  logic [WIDTH-1:0]    sum_w;
  logic                cout_w;

  pfx_classify #(.WIDTH(WIDTH)) u_cls (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .pos_o (stage[0]),
    .top_o (top_w)
  );

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    pfx_level #(.WIDTH(WIDTH), .DIST(1 << k)) u_lvl (
      .in_i  (stage[k]),
      .out_o (stage[k+1])
    );
  end

  pfx_sum #(.WIDTH(WIDTH)) u_sum (
    .a_i     (a_i),
    .b_i     (b_i),
    .pre_i   (stage[LEVELS]),
    .top_i   (top_w),
    .carry_o (carry_w),
    .sum_o   (sum_w),
    .cout_o  (cout_w)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_w;
        cout_o <= cout_w;
      end
    end
  end else begin : g_comb
    assign sum_o  = sum_w;
    assign cout_o = cout_w;
  end

endmodule

// File: rtl/pfx_cla_checker.sv
module pfx_cla_checker #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH:0]   carry_w
);

  logic [WIDTH:0] ref_w;
  logic           live;

  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_ff @(posedge clk) live <= rst_n;

  // R1: a produce bit always drives a carry upward
  p_gen_carries_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i & b_i) & ~carry_w[WIDTH:1]) == '0);

  // R1: a block bit never drives a carry upward
  p_kill_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((~a_i & ~b_i) & carry_w[WIDTH:1]) == '0);

  // R2: a pass bit hands on the state found below it
  p_prop_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i ^ b_i) & (carry_w[WIDTH:1] ^ carry_w[WIDTH-1:0])) == '0);

  // R3: the carry-in is the carry into bit 0
  p_cin_enters_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carry_w[0] == cin_i);

  if (REG_OUT) begin : g_reg_chk
    // R5, R7: registered result equals the add of the previous edge's operands
    p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> ({cout_o, sum_o} == $past(ref_w)));
  end else begin : g_comb_chk
    // R5, R8: combinational result equals the add of the current operands
    p_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      {cout_o, sum_o} == ref_w);
  end

endmodule

bind pfx_cla_adder pfx_cla_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .carry_w (carry_w)
);

// File: tb/tb_pfx_cla_adder.sv
module tb_pfx_cla_adder;

  localparam int W    = 32;
  localparam int NVEC = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  logic [3:0]   a4 = '0, b4 = '0;
  logic         cin4 = 1'b0;
  logic [3:0]   sum4;
  logic         cout4;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pfx_cla_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  pfx_cla_adder #(.WIDTH(4), .REG_OUT(1'b0)) dut_w4 (
    .clk(clk), .rst_n(rst_n), .a_i(a4), .b_i(b4), .cin_i(cin4),
    .sum_o(sum4), .cout_o(cout4)
  );

  // {a, b, cin, expected sum, expected carry-out}
  localparam logic [97:0] VEC [NVEC] = '{
    {32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0},
    {32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1},
    {32'hFFFFFFFF, 32'h00000000, 1'b0, 32'hFFFFFFFF, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFE, 1'b1},
    {32'h00000000, 32'h00000000, 1'b1, 32'h00000001, 1'b0},
    {32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b1},
    {32'h12345678, 32'h11111111, 1'b0, 32'h23456789, 1'b0},
    {32'hAAAAAAAA, 32'h55555555, 1'b0, 32'hFFFFFFFF, 1'b0},
    {32'hAAAAAAAA, 32'h55555555, 1'b1, 32'h00000000, 1'b1},
    {32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b0},
    {32'h0000FFFF, 32'h00000001, 1'b0, 32'h00010000, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      1, 9:     return "R4";
      2, 3:     return "R6";
      4, 6:     return "R1";
      5:        return "R3";
      8, 10, 11: return "R2";
      default:  return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  initial begin
    // R7: reset clears the outputs even with operands present
    a = 32'h00000005; b = 32'h00000003; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset", {cout, sum}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first result", {cout, sum}, 33'h9);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
      check(vec_tag(i), {cout, sum}, {VEC[i][0], VEC[i][32:1]});
    end

    // R7: one cycle of latency
    @(negedge clk);
    a = 32'h00000001; b = 32'h00000001; cin = 1'b0;
    @(negedge clk);
    a = 32'h10000000; b = 32'h10000000; cin = 1'b0;
    #1;
    check("R7 latency hold", {cout, sum}, 33'h2);
    @(negedge clk);
    check("R7 latency update", {cout, sum}, 33'h020000000);

    // R5: random wide vectors against a behavioural add
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] x, y;
      logic c;
      x = $urandom; y = $urandom; c = 1'($urandom);
      apply(x, y, c);
      check("R5 random", {cout, sum}, {1'b0, x} + {1'b0, y} + {32'b0, c});
    end

    // R7: reset in mid-run clears the outputs
    @(negedge clk);
    a = '1; b = '1; cin = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid reset", {cout, sum}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset", {cout, sum}, {1'b1, 32'hFFFFFFFF});

    // R8: exhaustive 4-bit combinational variant
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a4 = 4'(x); b4 = 4'(y); cin4 = 1'(c);
          #1;
          n_chk++;
          if ({cout4, sum4} !== 5'(x + y + c)) begin
            n_fail++;
            $display("FAIL R8: %0d+%0d+%0d got %h expected %h",
                     x, y, c, {cout4, sum4}, 5'(x + y + c));
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule